// File: doc/BRIEF.md
# Parameter Block Sequencer for a Disk Channel

This block runs one disk command. A single-cycle start pulse gives it the address of a ten-byte command block in system memory. It reads the ten bytes one at a time through a byte-wide read master. It then decodes the command and checks it.

Positioning commands are finished inside the block: seek, return-to-track-zero, no-operation and verify. Commands that move data are handed to a separate sector transfer engine, and the block waits for that engine's status. Every command ends with a one-cycle done pulse, an error byte and a result type, and it sets an interrupt flag that the register interface clears.

Two checks come before any action, and their order matters. The drive readiness check runs first. The sector/track range check runs second and does not apply to the return-to-track-zero command. The block keeps a head position register (track and sector) for each drive, which seek and return-to-track-zero update.

Top module: `param_block_exec`

## Requirements
- R1: After an accepted start, the block issues exactly ten one-byte reads at consecutive addresses from `blk_addr` upward. Each read holds `mem_req` and `mem_addr` steady until `mem_ack` and drops `mem_req` in the cycle after the acknowledge. Byte k lands in field k in this order: 0 channel word, 1 instruction, 2 record count, 3 track, 4 sector, 5 buffer low, 6 buffer high, 7 block number, 8 next-block low, 9 next-block high.
- R2: The command is instruction bits 2:0, encoded as 0 no-op, 1 seek, 2 format, 3 return-to-zero, 4 read, 5 verify, 6 write, 7 write deleted. The drive number is instruction bit 4; bit 5 and the other upper bits have no effect. Only bits 4:0 of the sector byte are used.
- R3: If the selected drive's `drive_ready` bit is 0, the command ends with error byte 0x80. No transfer starts and no head register changes.
- R4: On a ready drive, any command other than return-to-zero ends with error byte 0x08, and has no other effect, if any of these holds: the sector is 0, the sector is above 26, sector plus record count is above 27, or the track is above 76. Return-to-zero skips this check.
- R5: A valid seek loads the drive's head track and sector from the block. A valid return-to-zero loads the sector and clears the track. Both end with error byte 0x00.
- R6: A valid no-op or verify ends with error byte 0x00 and leaves the head registers unchanged.
- R7: A valid format, read, write or write-deleted command raises `xfer_start` for one cycle, presenting the command, drive, track, sector, record count and buffer address. It then ends with `result_byte` equal to the `xfer_status` that comes with `xfer_done`.
- R8: Every completion, error or not, pulses `done` for one cycle, sets `irq` and reports `result_type` 00. `irq_clr` clears `irq`; in the same cycle, a completion wins.
- R9: `busy` rises in the cycle after an accepted start and falls together with `done`. A start pulse while busy is ignored.
- R10: After reset, `busy`, `done`, `irq`, `mem_req`, `xfer_start`, `result_byte` and all head registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start |
| blk_addr | input | ADDR_W | Address of the command block |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Read acknowledge, one cycle, data valid |
| mem_data | input | 8 | Read data |
| drive_ready | input | NUM_DRIVES | Per-drive ready |
| xfer_start | output | 1 | Transfer engine launch pulse |
| xfer_op | output | 3 | Command code for the engine |
| xfer_drive | output | $clog2(NUM_DRIVES) | Drive for the engine |
| xfer_track | output | 8 | Track for the engine |
| xfer_sector | output | 5 | Sector for the engine |
| xfer_count | output | 8 | Record count for the engine |
| xfer_buf | output | 16 | Buffer address for the engine |
| xfer_done | input | 1 | Engine finished, one cycle |
| xfer_status | input | 8 | Engine error byte, valid with xfer_done |
| irq_clr | input | 1 | Clear the interrupt flag |
| done | output | 1 | Completion pulse |
| irq | output | 1 | Interrupt flag |
| result_type | output | 2 | Result type, always 00 |
| result_byte | output | 8 | Error byte of the last command |
| head_track | output | 8*NUM_DRIVES | Head track per drive, drive d at bits 8d+7:8d |
| head_sector | output | 5*NUM_DRIVES | Head sector per drive, drive d at bits 5d+4:5d |

## Verification
The properties assume a well-behaved memory and engine:
- `mem_ack` comes only while `mem_req` is high, as a single-cycle pulse.
- `xfer_done` comes only after `xfer_start`, as a single-cycle pulse.

The bench's responder keeps to these rules. It answers a request after a latency of zero to two cycles and clears the acknowledge at the next cycle. Its engine model returns status three cycles after each launch.

A second start is injected in the middle of a fetch on some runs. Readiness patterns rotate, so the bench reaches not-ready on each drive and on both drives.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  localparam int BLK_BYTES   = 10;
  localparam int SEC_BITS    = 5;
  localparam int DRV_LSB     = 4;
  // byte positions inside the fetched block (fetch order)
  localparam int F_CHAN      = 0;
  localparam int F_INSTR     = 1;
  localparam int F_COUNT     = 2;
  localparam int F_TRACK     = 3;
  localparam int F_SECTOR    = 4;
  localparam int F_BUF_LO    = 5;
  localparam int F_BUF_HI    = 6;
  localparam int F_BLOCK     = 7;
  localparam int F_NEXT_LO   = 8;
  localparam int F_NEXT_HI   = 9;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SEEK   = 3'd1,
    OP_FORMAT = 3'd2,
    OP_HOME   = 3'd3,
    OP_READ   = 3'd4,
    OP_VERIFY = 3'd5,
    OP_WRITE  = 3'd6,
    OP_WDEL   = 3'd7
  } pbx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EVAL, ST_XFER, ST_FIN
  } pbx_state_e;

  localparam logic [7:0] ERR_NONE      = 8'h00;
  localparam logic [7:0] ERR_ADDRESS   = 8'h08;
  localparam logic [7:0] ERR_NOT_READY = 8'h80;
endpackage

// File: rtl/pbx_fetch.sv
module pbx_fetch
  import pbx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   launch,
  input  logic [ADDR_W-1:0]      base_addr,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_ack,
  input  logic [7:0]             mem_data,
  output logic [BLK_BYTES*8-1:0] blk_bytes,
  output logic                   fetched
);
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  logic             active;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idx       <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      fetched   <= 1'b0;
      blk_bytes <= '0;
    end else begin
      fetched <= 1'b0;
      if (!active) begin
        if (launch) begin
          active   <= 1'b1;
          idx      <= '0;
          mem_addr <= base_addr;
          mem_req  <= 1'b1;
        end
      end else if (mem_req) begin
        if (mem_ack) begin
          blk_bytes[idx*8 +: 8] <= mem_data;
          mem_req <= 1'b0;
          if (idx == LAST_IDX) begin
            active  <= 1'b0;
            fetched <= 1'b1;
          end else begin
            idx      <= idx + IDX_W'(1);
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
      end else begin
        mem_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbx_check.sv
module pbx_check
  import pbx_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int MAX_SECTOR = 26,
  parameter int MAX_TRACK  = 76,
  localparam int DRV_W     = $clog2(NUM_DRIVES)
) (
  input  logic [2:0]            op_raw,
  input  logic [DRV_W-1:0]      drv,
  input  logic [SEC_BITS-1:0]   sector,
  input  logic [7:0]            count,
  input  logic [7:0]            track,
  input  logic [NUM_DRIVES-1:0] drive_ready,
  output pbx_op_e               op,
  output logic                  not_ready,
  output logic                  addr_err
);
  localparam logic [SEC_BITS-1:0] SEC_LIMIT = SEC_BITS'(MAX_SECTOR);
  localparam logic [8:0]          SUM_LIMIT = 9'(MAX_SECTOR + 1);
  localparam logic [7:0]          TRK_LIMIT = 8'(MAX_TRACK);

  logic [8:0] span_end;

  always_comb begin
    op        = pbx_op_e'(op_raw);
    not_ready = ~drive_ready[drv];
    span_end  = {1'b0, count} + 9'(sector);
    addr_err  = (op != OP_HOME) &&
                ((sector == '0) || (sector > SEC_LIMIT) ||
                 (span_end > SUM_LIMIT) || (track > TRK_LIMIT));
  end
endmodule

// File: rtl/pbx_heads.sv
module pbx_heads
  import pbx_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  localparam int DRV_W     = $clog2(NUM_DRIVES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [DRV_W-1:0]               wr_drv,
  input  logic [7:0]                     wr_track,
  input  logic [SEC_BITS-1:0]            wr_sector,
  output logic [NUM_DRIVES*8-1:0]        head_track,
  output logic [NUM_DRIVES*SEC_BITS-1:0] head_sector
);
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    logic [7:0]          trk_q;
    logic [SEC_BITS-1:0] sec_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        trk_q <= '0;
        sec_q <= '0;
      end else if (wr_en && (wr_drv == DRV_W'(d))) begin
        trk_q <= wr_track;
        sec_q <= wr_sector;
      end
    end
    assign head_track[d*8 +: 8]               = trk_q;
    assign head_sector[d*SEC_BITS +: SEC_BITS] = sec_q;
  end
endmodule

// File: rtl/param_block_exec.sv
module param_block_exec
  import pbx_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_DRIVES = 2,
  parameter int MAX_SECTOR = 26,
  parameter int MAX_TRACK  = 76
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              blk_addr,
  output logic                           busy,
  output logic                           mem_req,
  output logic [ADDR_W-1:0]              mem_addr,
  input  logic                           mem_ack,
  input  logic [7:0]                     mem_data,
  input  logic [NUM_DRIVES-1:0]          drive_ready,
  output logic                           xfer_start,
  output logic [2:0]                     xfer_op,
  output logic [$clog2(NUM_DRIVES)-1:0]  xfer_drive,
  output logic [7:0]                     xfer_track,
  output logic [4:0]                     xfer_sector,
  output logic [7:0]                     xfer_count,
  output logic [15:0]                    xfer_buf,
  input  logic                           xfer_done,
  input  logic [7:0]                     xfer_status,
  input  logic                           irq_clr,
  output logic                           done,
  output logic                           irq,
  output logic [1:0]                     result_type,
  output logic [7:0]                     result_byte,
  output logic [NUM_DRIVES*8-1:0]        head_track,
  output logic [NUM_DRIVES*5-1:0]        head_sector
);
  localparam int DRV_W = $clog2(NUM_DRIVES);

  pbx_state_e                 state;
  logic [7:0]                 err_q;
  logic [BLK_BYTES*8-1:0]     blk;
  logic                       fetched;
  logic                       launch;
  pbx_op_e                    op;
  logic                       not_ready;
  logic                       addr_err;
  logic                       head_wr;
  logic [7:0]                 instr;
  logic [7:0]                 sector_raw;
  logic                       unused_fields;

  assign launch     = (state == ST_IDLE) && start;
  assign busy       = (state != ST_IDLE);
  assign instr      = blk[F_INSTR*8 +: 8];
  assign sector_raw = blk[F_SECTOR*8 +: 8];

  assign xfer_op     = instr[2:0];
  assign xfer_drive  = instr[DRV_LSB +: DRV_W];
  assign xfer_track  = blk[F_TRACK*8 +: 8];
  assign xfer_sector = sector_raw[SEC_BITS-1:0];
  assign xfer_count  = blk[F_COUNT*8 +: 8];
  assign xfer_buf    = {blk[F_BUF_HI*8 +: 8], blk[F_BUF_LO*8 +: 8]};

  // fields fetched for completeness but not acted on by this block
  assign unused_fields = ^{blk[F_CHAN*8 +: 8], blk[F_BLOCK*8 +: 8],
                           blk[F_NEXT_LO*8 +: 8], blk[F_NEXT_HI*8 +: 8],
                           instr[7:DRV_LSB+DRV_W], instr[3],
                           sector_raw[7:SEC_BITS]};

  pbx_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .base_addr (blk_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_data  (mem_data),
    .blk_bytes (blk),
    .fetched   (fetched)
  );

  pbx_check #(
    .NUM_DRIVES (NUM_DRIVES),
    .MAX_SECTOR (MAX_SECTOR),
    .MAX_TRACK  (MAX_TRACK)
  ) u_check (
    .op_raw      (xfer_op),
    .drv         (xfer_drive),
    .sector      (xfer_sector),
    .count       (xfer_count),
    .track       (xfer_track),
    .drive_ready (drive_ready),
    .op          (op),
    .not_ready   (not_ready),
    .addr_err    (addr_err)
  );

  assign head_wr = (state == ST_EVAL) && !not_ready && !addr_err &&
                   ((op == OP_SEEK) || (op == OP_HOME));

  pbx_heads #(.NUM_DRIVES(NUM_DRIVES)) u_heads (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (head_wr),
    .wr_drv      (xfer_drive),
    .wr_track    ((op == OP_HOME) ? 8'h00 : xfer_track),
    .wr_sector   (xfer_sector),
    .head_track  (head_track),
    .head_sector (head_sector)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      err_q       <= ERR_NONE;
      xfer_start  <= 1'b0;
      done        <= 1'b0;
      irq         <= 1'b0;
      result_type <= 2'b00;
      result_byte <= 8'h00;
    end else begin
      xfer_start <= 1'b0;
      done       <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: if (fetched) state <= ST_EVAL;
        ST_EVAL: begin
          if (not_ready) begin
            err_q <= ERR_NOT_READY;
            state <= ST_FIN;
          end else if (addr_err) begin
            err_q <= ERR_ADDRESS;
            state <= ST_FIN;
          end else begin
            unique case (op)
              OP_FORMAT, OP_READ, OP_WRITE, OP_WDEL: begin
                xfer_start <= 1'b1;
                state      <= ST_XFER;
              end
              default: begin
                err_q <= ERR_NONE;
                state <= ST_FIN;
              end
            endcase
          end
        end
        ST_XFER: if (xfer_done) begin
          err_q <= xfer_status;
          state <= ST_FIN;
        end
        ST_FIN: begin
          done        <= 1'b1;
          irq         <= 1'b1;
          result_type <= 2'b00;
          result_byte <= err_q;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbx_checker.sv
module pbx_checker #(
  parameter int ADDR_W     = 16,
  parameter int NUM_DRIVES = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    xfer_start,
  input logic                    done,
  input logic                    irq,
  input logic [NUM_DRIVES*8-1:0] head_track,
  input logic [NUM_DRIVES*5-1:0] head_sector
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R1
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req); // R1
  AST_HEADS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(head_track) && $stable(head_sector)); // R5
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R7
  AST_XFER_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
    done |-> irq); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_IDLE_NOREQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R9
endmodule

bind param_block_exec pbx_checker #(
  .ADDR_W     (ADDR_W),
  .NUM_DRIVES (NUM_DRIVES)
) u_pbx_checker (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .xfer_start  (xfer_start),
  .done        (done),
  .irq         (irq),
  .head_track  (head_track),
  .head_sector (head_sector)
);

// File: tb/param_block_exec_tb_top.sv
`timescale 1ns/1ps
module param_block_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] blk_addr = '0;
  logic        busy, mem_req, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic [1:0]  drive_ready = 2'b11;
  logic        xfer_start;
  logic [2:0]  xfer_op;
  logic [0:0]  xfer_drive;
  logic [7:0]  xfer_track, xfer_count;
  logic [4:0]  xfer_sector;
  logic [15:0] xfer_buf;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_status = '0;
  logic        irq_clr = 1'b0;
  logic        done, irq;
  logic [1:0]  result_type;
  logic [7:0]  result_byte;
  logic [15:0] head_track;
  logic [9:0]  head_sector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] mem [64];
  logic [7:0] hd_trk [2];
  logic [4:0] hd_sec [2];

  always #2.5 clk = ~clk;

  param_block_exec dut_i (
    .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .drive_ready(drive_ready), .xfer_start(xfer_start), .xfer_op(xfer_op),
    .xfer_drive(xfer_drive), .xfer_track(xfer_track), .xfer_sector(xfer_sector),
    .xfer_count(xfer_count), .xfer_buf(xfer_buf), .xfer_done(xfer_done),
    .xfer_status(xfer_status), .irq_clr(irq_clr), .done(done), .irq(irq),
    .result_type(result_type), .result_byte(result_byte),
    .head_track(head_track), .head_sector(head_sector)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] op, input logic drv, input logic [4:0] sec,
                         input logic [7:0] cnt, input logic [7:0] trk, input int idx);
    logic [15:0] base;
    logic [7:0]  b [10];
    logic [1:0]  rdy;
    int lat, lat_cnt, nreads, addr_bad, xseen, xcnt, cyc;
    bit nr, ae, xf;
    logic [7:0] exp_err;
    string tag;
    logic [2:0] c_op; logic c_drv; logic [4:0] c_sec; logic [7:0] c_trk, c_cnt;
    logic [15:0] c_buf;

    base = 16'h1200 + 16'(idx % 50);
    b[0] = 8'(idx * 7);
    b[1] = {2'b00, idx[0], drv, idx[1], op};
    b[2] = cnt;
    b[3] = trk;
    b[4] = {idx[4:2], sec};
    b[5] = 8'(idx);
    b[6] = 8'(idx >> 8) ^ 8'h5A;
    b[7] = 8'(idx + 1);
    b[8] = 8'(idx + 2);
    b[9] = 8'(idx + 3);
    for (int k = 0; k < 10; k++) mem[6'(base + 16'(k))] = b[k];
    case (idx % 5)
      0: rdy = 2'b00;
      1: rdy = 2'b01;
      2: rdy = 2'b10;
      default: rdy = 2'b11;
    endcase
    lat = idx % 3;

    nr = !rdy[drv];
    ae = (op != 3'd3) && (sec == 0 || sec > 26 || int'(sec) + int'(cnt) > 27 || trk > 76);
    xf = !nr && !ae && (op == 3'd2 || op == 3'd4 || op == 3'd6 || op == 3'd7);
    if (nr)      begin exp_err = 8'h80; tag = "R3 not-ready"; end
    else if (ae) begin exp_err = 8'h08; tag = "R4 address"; end
    else if (xf) begin exp_err = trk ^ cnt; tag = "R7 engine status"; end
    else if (op == 3'd1 || op == 3'd3) begin exp_err = 8'h00; tag = "R5 position"; end
    else begin exp_err = 8'h00; tag = "R6 no-op/verify"; end
    if (!nr && !ae && op == 3'd1) begin hd_trk[drv] = trk; hd_sec[drv] = sec; end
    if (!nr && !ae && op == 3'd3) begin hd_trk[drv] = 8'h00; hd_sec[drv] = sec; end

    drive_ready = rdy;
    blk_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);

    lat_cnt = 0; nreads = 0; addr_bad = 0; xseen = 0; xcnt = 0; cyc = 0;
    c_op = '0; c_drv = '0; c_sec = '0; c_trk = '0; c_cnt = '0; c_buf = '0;
    while (1) begin
      if (done === 1'b1) break;
      xfer_done = 1'b0;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat_cnt == lat) begin
          if (mem_addr !== base + 16'(nreads)) addr_bad++;
          mem_data = mem[6'(mem_addr)];
          mem_ack = 1'b1;
          nreads++;
          lat_cnt = 0;
        end else lat_cnt++;
      end
      if (xfer_start) begin
        xseen++;
        c_op = xfer_op; c_drv = xfer_drive[0]; c_sec = xfer_sector;
        c_trk = xfer_track; c_cnt = xfer_count; c_buf = xfer_buf;
        xcnt = 3;
      end else if (xcnt > 0) begin
        xcnt--;
        if (xcnt == 0) begin
          xfer_done = 1'b1;
          xfer_status = trk ^ cnt;
        end
      end
      if (cyc == 4 && idx % 7 == 3) begin
        start = 1'b1;                 // R9: must be ignored while busy
        blk_addr = base + 16'h0100;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (cyc > 400) break;
    end
    start = 1'b0;
    xfer_done = 1'b0;

    chk(nreads == 10, "R1 read count", nreads, 10);
    chk(addr_bad == 0, "R1 address sequence", addr_bad, 0);
    chk(result_byte === exp_err, tag, int'(result_byte), int'(exp_err));
    chk(result_type === 2'b00, "R8 result type", int'(result_type), 0);
    chk(irq === 1'b1, "R8 irq set", int'(irq), 1);
    chk(xseen == (xf ? 1 : 0), xf ? "R7 dispatch" : "R3/R4/R6 no dispatch", xseen, xf ? 1 : 0);
    if (xf) begin
      chk(c_op == op, "R2 opcode field", int'(c_op), int'(op));
      chk(c_drv == drv, "R2 drive bit", int'(c_drv), int'(drv));
      chk(c_sec == sec, "R2 sector low bits", int'(c_sec), int'(sec));
      chk(c_trk == trk && c_cnt == cnt, "R7 track/count", int'({c_trk, c_cnt}), int'({trk, cnt}));
      chk(c_buf == {b[6], b[5]}, "R7 buffer address", int'(c_buf), int'({b[6], b[5]}));
    end
    for (int d = 0; d < 2; d++) begin
      chk(head_track[d*8 +: 8] === hd_trk[d], "R5 head track", int'(head_track[d*8 +: 8]), int'(hd_trk[d]));
      chk(head_sector[d*5 +: 5] === hd_sec[d], "R5 head sector", int'(head_sector[d*5 +: 5]), int'(hd_sec[d]));
    end
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", int'(done), 0);
    chk(busy === 1'b0, "R9 idle after done", int'(busy), 0);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq === 1'b0, "R8 irq clear", int'(irq), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    hd_trk[0] = 0; hd_trk[1] = 0; hd_sec[0] = 0; hd_sec[1] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && irq === 1'b0, "R10 reset flags",
        int'({busy, done, irq}), 0);
    chk(mem_req === 1'b0 && xfer_start === 1'b0, "R10 reset requests",
        int'({mem_req, xfer_start}), 0);
    chk(result_byte === 8'h00, "R10 reset result", int'(result_byte), 0);
    chk(head_track === '0 && head_sector === '0, "R10 reset heads",
        int'(head_track) + int'(head_sector), 0);
    begin
      logic [4:0] secs [8];
      logic [7:0] cnts [4];
      logic [7:0] trks [4];
      int idx;
      secs = '{5'd0, 5'd1, 5'd2, 5'd13, 5'd25, 5'd26, 5'd27, 5'd31};
      cnts = '{8'd0, 8'd1, 8'd2, 8'd26};
      trks = '{8'd0, 8'd76, 8'd77, 8'd255};
      idx = 0;
      for (int o = 0; o < 8; o++)
        for (int dv = 0; dv < 2; dv++)
          for (int s = 0; s < 8; s++)
            for (int c = 0; c < 4; c++)
              for (int t = 0; t < 4; t++) begin
                run_one(3'(o), 1'(dv), secs[s], cnts[c], trks[t], idx);
                idx++;
              end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule